// File: doc/BRIEF.md
# Memory-Operand Byte Decoder for 64-bit Mode

This block decodes the addressing bytes that follow the opcode of a 64-bit-mode instruction. Three register-extension bits come in on side-band pins: a reg extension, an index extension and a base extension. Bytes then arrive one per accepted handshake: first the addressing-form byte, then an optional scale/index/base byte, and then an optional displacement of one or four bytes. For each operand the block reports the reg-field register number, the base register and its presence flag, the index register with its presence flag and scale, an instruction-pointer-relative flag, a 32-bit sign-extended displacement, and the number of addressing bytes it consumed.

The block decides how many bytes to take from the 3-bit fields alone. The base extension bit never changes the length; it only widens the reported register number. As a result, register 13 is encoded exactly like register 5 and register 12 exactly like register 4. The no-index test does look at the index extension bit, so register 12 can serve as an index while register 4 cannot. When the last byte is accepted, a one-cycle done pulse appears with the results. The results stay held until the next decode completes.

Top module: `memop_decoder`

## Requirements
- R1: While rst_n is low, in_ready and done are 0 and every result output is 0. in_ready is 1 from the first clock edge after reset is released.
- R2: reg_num equals {rex_r, first-byte bits 5:3}. The extension bits are sampled when the first byte is accepted.
- R3: A first byte with bits 7:6 = 11 is register direct: base_num = {rex_b, bits 2:0}, base_en = 1, no index, disp = 0, scale = 1, byte_count = 1.
- R4: A first byte with bits 7:6 = 00 and bits 2:0 = 101 sets rip_rel = 1, base_en = 0 and base_num = 0. A 4-byte displacement follows and byte_count = 5.
- R5: First-byte bits 2:0 = 100 with bits 7:6 other than 11 mean a second (scale/index/base) byte follows. Its bits 2:0 = 100 name base 4, or base 12 when rex_b = 1.
- R6: In the second byte, bits 2:0 = 101 together with first-byte bits 7:6 = 00 give base_en = 0 and base_num = 0, and a 4-byte displacement follows.
- R7: Second-byte bits 5:3 = 100 with rex_x = 0 give index_en = 0 and index_num = 0. Any other combination gives index_en = 1 and index_num = {rex_x, bits 5:3}. Register 4 is therefore never reported as an index.
- R8: rex_b never changes the byte count. With rex_b = 1, base code 101 behaves exactly as it does with rex_b = 0.
- R9: First-byte bits 7:6 = 01 add one displacement byte, sign-extended to 32 bits. Bits 7:6 = 10 add four bytes, least significant byte first.
- R10: scale equals 1 shifted left by second-byte bits 7:6, giving 1, 2, 4 or 8. It is 1 when no second byte is present.
- R11: done is high for exactly the one cycle after the last byte is accepted. Cycles with in_valid low consume nothing. The results hold until the next done.
- R12: Asserting reset part-way through an operand discards it. The next byte after release is taken as a new first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rex_r | input | 1 | Extension bit for the reg field |
| rex_x | input | 1 | Extension bit for the index field |
| rex_b | input | 1 | Extension bit for the base / register-direct field |
| in_valid | input | 1 | in_byte carries an addressing byte |
| in_byte | input | 8 | Addressing byte stream |
| in_ready | output | 1 | Block can accept a byte |
| done | output | 1 | Results valid, one-cycle pulse |
| reg_num | output | 4 | Reg-field register number |
| base_num | output | 4 | Base register number (0 when absent) |
| base_en | output | 1 | Base register present |
| index_num | output | 4 | Index register number (0 when absent) |
| index_en | output | 1 | Index register present |
| scale | output | 4 | Index scale: 1, 2, 4 or 8 |
| rip_rel | output | 1 | Address is instruction-pointer relative |
| disp | output | 32 | Sign-extended displacement |
| byte_count | output | 3 | Addressing bytes consumed (1 to 6) |

## Verification
The hardest situations to reach are the ones where the extension bits must not matter for length. Examples are base code 101 under rex_b = 1 with and without a displacement, and index code 100 under both values of rex_x. The stimulus table pairs each such encoding with its extension bits and a full expected result. A paced run with junk on in_byte during idle cycles shows that nothing is consumed without in_valid. A reset issued midway through a displacement, followed by a fresh operand, shows that partial state is discarded.

// File: rtl/memop_pkg.sv
package memop_pkg;
  typedef enum logic [1:0] {PH_FIRST, PH_SIB, PH_DISP} phase_e;
  typedef enum logic [1:0] {DL_NONE, DL_ONE, DL_WIDE} dlen_e;

  localparam logic [1:0] MOD_NODISP = 2'b00;
  localparam logic [1:0] MOD_D8     = 2'b01;
  localparam logic [1:0] MOD_D32    = 2'b10;
  localparam logic [1:0] MOD_REG    = 2'b11;
  localparam logic [2:0] RM_ESC_SIB = 3'b100;
  localparam logic [2:0] RM_NOBASE  = 3'b101;
  localparam logic [2:0] IDX_NONE   = 3'b100;

  function automatic dlen_e disp_for_mod(input logic [1:0] m);
    case (m)
      MOD_D8:  return DL_ONE;
      MOD_D32: return DL_WIDE;
      default: return DL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/memop_first_dec.sv
module memop_first_dec
  import memop_pkg::*;
(
  input  logic [7:0] byte_in,
  input  logic       ext_r,
  input  logic       ext_b,
  output logic [1:0] mod_f,
  output logic [3:0] reg_num,
  output logic       want_sib,
  output logic       rip_rel,
  output logic       base_en,
  output logic [3:0] base_num,
  output dlen_e      dlen
);
  logic [2:0] rm;
  assign mod_f   = byte_in[7:6];
  assign rm      = byte_in[2:0];
  assign reg_num = {ext_r, byte_in[5:3]};

  always_comb begin
    want_sib = (mod_f != MOD_REG) && (rm == RM_ESC_SIB);
    rip_rel  = (mod_f == MOD_NODISP) && (rm == RM_NOBASE);
    base_en  = !rip_rel && !want_sib;
    base_num = base_en ? {ext_b, rm} : 4'd0;
    if (mod_f == MOD_REG)  dlen = DL_NONE;
    else if (rip_rel)      dlen = DL_WIDE;
    else                   dlen = disp_for_mod(mod_f);
  end
endmodule

// File: rtl/memop_sib_dec.sv
module memop_sib_dec
  import memop_pkg::*;
(
  input  logic [7:0] byte_in,
  input  logic [1:0] mod_f,
  input  logic       ext_x,
  input  logic       ext_b,
  output logic       index_en,
  output logic [3:0] index_num,
  output logic [3:0] scale,
  output logic       base_en,
  output logic [3:0] base_num,
  output dlen_e      dlen
);
  logic [2:0] idx, bs;
  assign idx = byte_in[5:3];
  assign bs  = byte_in[2:0];

  always_comb begin
    index_en  = !((idx == IDX_NONE) && !ext_x);
    index_num = index_en ? {ext_x, idx} : 4'd0;
    scale     = 4'd1 << byte_in[7:6];
    base_en   = !((mod_f == MOD_NODISP) && (bs == RM_NOBASE));
    base_num  = base_en ? {ext_b, bs} : 4'd0;
    dlen      = base_en ? disp_for_mod(mod_f) : DL_WIDE;
  end
endmodule

// File: rtl/memop_disp_acc.sv
module memop_disp_acc #(
  parameter int DISP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [7:0]        byte_in,
  output logic [DISP_W-1:0] acc_next
);
  logic [DISP_W-1:0] acc_q;
  assign acc_next = {byte_in, acc_q[DISP_W-1:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (shift_en) acc_q <= acc_next;
  end
endmodule

// File: rtl/memop_decoder.sv
module memop_decoder
  import memop_pkg::*;
#(
  parameter int DISP_W = 32,
  localparam int DISP_BYTES = DISP_W / 8,
  localparam int MAX_LEN = DISP_BYTES + 2,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rex_r,
  input  logic              rex_x,
  input  logic              rex_b,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              done,
  output logic [3:0]        reg_num,
  output logic [3:0]        base_num,
  output logic              base_en,
  output logic [3:0]        index_num,
  output logic              index_en,
  output logic [3:0]        scale,
  output logic              rip_rel,
  output logic [DISP_W-1:0] disp,
  output logic [CNT_W-1:0]  byte_count
);
  // decoder outputs
  logic [1:0] f_mod;
  logic [3:0] f_reg, f_base;
  logic f_sib, f_rip, f_ben;
  dlen_e f_dlen;
  logic s_ien, s_ben;
  logic [3:0] s_idx, s_scale, s_base;
  dlen_e s_dlen;
  logic [DISP_W-1:0] acc_next;

  // working state
  phase_e phase_q, phase_n;
  logic [1:0] mod_q, mod_n;
  logic rexx_q, rexx_n, rexb_q, rexb_n, one_q, one_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, left_q, left_n;
  logic [3:0] wreg_q, wreg_n, wbase_q, wbase_n, widx_q, widx_n, wscale_q, wscale_n;
  logic wben_q, wben_n, wien_q, wien_n, wrip_q, wrip_n;
  logic rdy_q, done_q, fire, finish, shift_en;
  logic [DISP_W-1:0] fin_disp;

  // result registers
  logic [3:0] o_reg_q, o_base_q, o_idx_q, o_scale_q;
  logic o_ben_q, o_ien_q, o_rip_q;
  logic [DISP_W-1:0] o_disp_q;
  logic [CNT_W-1:0] o_cnt_q;

  memop_first_dec u_first (
    .byte_in(in_byte), .ext_r(rex_r), .ext_b(rex_b), .mod_f(f_mod),
    .reg_num(f_reg), .want_sib(f_sib), .rip_rel(f_rip), .base_en(f_ben),
    .base_num(f_base), .dlen(f_dlen)
  );

  memop_sib_dec u_sib (
    .byte_in(in_byte), .mod_f(mod_q), .ext_x(rexx_q), .ext_b(rexb_q),
    .index_en(s_ien), .index_num(s_idx), .scale(s_scale), .base_en(s_ben),
    .base_num(s_base), .dlen(s_dlen)
  );

  memop_disp_acc #(.DISP_W(DISP_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .byte_in(in_byte),
    .acc_next(acc_next)
  );

  assign fire = in_valid && rdy_q;

  always_comb begin
    phase_n = phase_q;  mod_n = mod_q;  rexx_n = rexx_q;  rexb_n = rexb_q;
    one_n = one_q;  cnt_n = cnt_q;  left_n = left_q;
    wreg_n = wreg_q;  wbase_n = wbase_q;  widx_n = widx_q;  wscale_n = wscale_q;
    wben_n = wben_q;  wien_n = wien_q;  wrip_n = wrip_q;
    finish = 1'b0;  shift_en = 1'b0;  fin_disp = '0;
    if (fire) begin
      cnt_n = cnt_q + CNT_W'(1);
      case (phase_q)
        PH_FIRST: begin
          cnt_n = CNT_W'(1);
          mod_n = f_mod;  rexx_n = rex_x;  rexb_n = rex_b;
          wreg_n = f_reg;  wbase_n = f_base;  wben_n = f_ben;  wrip_n = f_rip;
          widx_n = 4'd0;  wien_n = 1'b0;  wscale_n = 4'd1;
          if (f_sib) phase_n = PH_SIB;
          else if (f_dlen == DL_NONE) finish = 1'b1;
          else begin
            phase_n = PH_DISP;
            one_n   = (f_dlen == DL_ONE);
            left_n  = (f_dlen == DL_ONE) ? CNT_W'(1) : CNT_W'(DISP_BYTES);
          end
        end
        PH_SIB: begin
          widx_n = s_idx;  wien_n = s_ien;  wscale_n = s_scale;
          wbase_n = s_base;  wben_n = s_ben;
          if (s_dlen == DL_NONE) begin
            finish  = 1'b1;
            phase_n = PH_FIRST;
          end else begin
            phase_n = PH_DISP;
            one_n   = (s_dlen == DL_ONE);
            left_n  = (s_dlen == DL_ONE) ? CNT_W'(1) : CNT_W'(DISP_BYTES);
          end
        end
        default: begin
          shift_en = 1'b1;
          left_n   = left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            finish   = 1'b1;
            phase_n  = PH_FIRST;
            fin_disp = one_q ? {{(DISP_W-8){in_byte[7]}}, in_byte} : acc_next;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;  mod_q <= '0;  rexx_q <= 1'b0;  rexb_q <= 1'b0;
      one_q <= 1'b0;  cnt_q <= '0;  left_q <= '0;
      wreg_q <= '0;  wbase_q <= '0;  widx_q <= '0;  wscale_q <= '0;
      wben_q <= 1'b0;  wien_q <= 1'b0;  wrip_q <= 1'b0;
      rdy_q <= 1'b0;  done_q <= 1'b0;
    end else begin
      phase_q <= phase_n;  mod_q <= mod_n;  rexx_q <= rexx_n;  rexb_q <= rexb_n;
      one_q <= one_n;  cnt_q <= cnt_n;  left_q <= left_n;
      wreg_q <= wreg_n;  wbase_q <= wbase_n;  widx_q <= widx_n;  wscale_q <= wscale_n;
      wben_q <= wben_n;  wien_q <= wien_n;  wrip_q <= wrip_n;
      rdy_q <= 1'b1;  done_q <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_reg_q <= '0;  o_base_q <= '0;  o_idx_q <= '0;  o_scale_q <= '0;
      o_ben_q <= 1'b0;  o_ien_q <= 1'b0;  o_rip_q <= 1'b0;
      o_disp_q <= '0;  o_cnt_q <= '0;
    end else if (finish) begin
      o_reg_q <= wreg_n;  o_base_q <= wbase_n;  o_idx_q <= widx_n;  o_scale_q <= wscale_n;
      o_ben_q <= wben_n;  o_ien_q <= wien_n;  o_rip_q <= wrip_n;
      o_disp_q <= fin_disp;  o_cnt_q <= cnt_n;
    end
  end

  assign in_ready   = rdy_q;
  assign done       = done_q;
  assign reg_num    = o_reg_q;
  assign base_num   = o_base_q;
  assign base_en    = o_ben_q;
  assign index_num  = o_idx_q;
  assign index_en   = o_ien_q;
  assign scale      = o_scale_q;
  assign rip_rel    = o_rip_q;
  assign disp       = o_disp_q;
  assign byte_count = o_cnt_q;
endmodule

// File: rtl/memop_decoder_chk.sv
module memop_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        done,
  input logic [3:0]  reg_num,
  input logic [3:0]  base_num,
  input logic        base_en,
  input logic [3:0]  index_num,
  input logic        index_en,
  input logic [3:0]  scale,
  input logic        rip_rel,
  input logic [31:0] disp,
  input logic [2:0]  byte_count
);
  // R4
  rip_excl_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(rip_rel && base_en));

  // R4
  rip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rip_rel) |-> (byte_count == 3'd5));

  // R7
  no_rsp_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && index_en) |-> (index_num != 4'd4));

  // R10
  scale_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(scale) == 1));

  // R3
  single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && byte_count == 3'd1) |-> (base_en && !index_en && disp == 32'd0));

  // R11
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_ready));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({reg_num, base_num, base_en, index_num, index_en,
                       scale, rip_rel, disp, byte_count}));
endmodule

bind memop_decoder memop_decoder_chk u_chk (.*);

// File: tb/memop_decoder_bench.sv
module memop_decoder_bench;
  typedef struct packed {
    logic [2:0]  rex;      // {r, x, b}
    logic [2:0]  nb;
    logic [47:0] bytes;    // first byte in bits 47:40
    logic [3:0]  e_reg;
    logic [3:0]  e_base;
    logic        e_ben;
    logic [3:0]  e_idx;
    logic        e_ien;
    logic [3:0]  e_scale;
    logic        e_rip;
    logic [31:0] e_disp;
    logic [2:0]  e_cnt;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'b001, 3'd1, 48'h030000000000, 4'd0,  4'd11, 1'b1, 4'd0,  1'b0, 4'd1, 1'b0, 32'h0,        3'd1, 4'd2},  // R2
    '{3'b001, 3'd2, 48'h042400000000, 4'd0,  4'd12, 1'b1, 4'd0,  1'b0, 4'd1, 1'b0, 32'h0,        3'd2, 4'd5},  // R5
    '{3'b001, 3'd2, 48'h450000000000, 4'd0,  4'd13, 1'b1, 4'd0,  1'b0, 4'd1, 1'b0, 32'h0,        3'd2, 4'd8},  // R8
    '{3'b011, 3'd2, 48'h04e300000000, 4'd0,  4'd11, 1'b1, 4'd12, 1'b1, 4'd8, 1'b0, 32'h0,        3'd2, 4'd7},  // R7
    '{3'b000, 3'd5, 48'h057856341200, 4'd0,  4'd0,  1'b0, 4'd0,  1'b0, 4'd1, 1'b1, 32'h12345678, 3'd5, 4'd4},  // R4
    '{3'b101, 3'd1, 48'hd90000000000, 4'd11, 4'd9,  1'b1, 4'd0,  1'b0, 4'd1, 1'b0, 32'h0,        3'd1, 4'd3},  // R3
    '{3'b000, 3'd2, 48'h4ef000000000, 4'd1,  4'd6,  1'b1, 4'd0,  1'b0, 4'd1, 1'b0, 32'hfffffff0, 3'd2, 4'd9},  // R9
    '{3'b001, 3'd5, 48'h970102038400, 4'd2,  4'd15, 1'b1, 4'd0,  1'b0, 4'd1, 1'b0, 32'h84030201, 3'd5, 4'd9},  // R9
    '{3'b000, 3'd6, 48'h046510203040, 4'd0,  4'd0,  1'b0, 4'd0,  1'b0, 4'd2, 1'b0, 32'h40302010, 3'd6, 4'd6},  // R6
    '{3'b010, 3'd3, 48'h448d7f000000, 4'd0,  4'd5,  1'b1, 4'd9,  1'b1, 4'd4, 1'b0, 32'h7f,       3'd3, 4'd10}, // R10
    '{3'b001, 3'd6, 48'h0c2dffffffff, 4'd1,  4'd0,  1'b0, 4'd5,  1'b1, 4'd1, 1'b0, 32'hffffffff, 3'd6, 4'd8},  // R8
    '{3'b000, 3'd6, 48'h842400000080, 4'd0,  4'd4,  1'b1, 4'd0,  1'b0, 4'd1, 1'b0, 32'h80000000, 3'd6, 4'd5}   // R5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rex_r = 1'b0, rex_x = 1'b0, rex_b = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, done, base_en, index_en, rip_rel;
  logic [3:0] reg_num, base_num, index_num, scale;
  logic [31:0] disp;
  logic [2:0] byte_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  memop_decoder u_memop_decoder (
    .clk(clk), .rst_n(rst_n), .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready), .done(done),
    .reg_num(reg_num), .base_num(base_num), .base_en(base_en),
    .index_num(index_num), .index_en(index_en), .scale(scale),
    .rip_rel(rip_rel), .disp(disp), .byte_count(byte_count)
  );

  function automatic logic [53:0] observed();
    return {reg_num, base_num, base_en, index_num, index_en, scale, rip_rel, disp, byte_count};
  endfunction

  function automatic logic [53:0] expected(input vec_t v);
    return {v.e_reg, v.e_base, v.e_ben, v.e_idx, v.e_ien, v.e_scale, v.e_rip, v.e_disp, v.e_cnt};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Sends a vector; gap idle cycles with junk bytes between bytes. Samples at the
  // negedge after the posedge that accepted the last byte, where done is high.
  task automatic run_vec(input vec_t v, input int gap, output bit gap_done_seen);
    gap_done_seen = 1'b0;
    {rex_r, rex_x, rex_b} = v.rex;
    for (int i = 0; i < int'(v.nb); i++) begin
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_byte  = 8'hff;
          if (done) gap_done_seen = 1'b1;
        end
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = v.bytes[47-8*i -: 8];
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'h00;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit gseen;
    logic [53:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!in_ready && !done, "R1 ready/done in reset", {62'd0, in_ready, done}, 64'd0);
    check(observed() == 54'd0, "R1 results in reset", 64'(observed()), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after release", 64'(in_ready), 64'd1);

    // table walk: R2..R10
    for (int k = 0; k < NV; k++) begin
      run_vec(VECS[k], 0, gseen);
      check(done == 1'b1, $sformatf("R11 done for vector %0d", k), 64'(done), 64'd1);
      check(observed() == expected(VECS[k]),
            $sformatf("R%0d vector %0d", VECS[k].req, k),
            64'(observed()), 64'(expected(VECS[k])));
    end

    // R11: paced delivery with junk bytes while in_valid is low
    run_vec(VECS[7], 2, gseen);
    check(!gseen, "R11 no done during gaps", 64'(gseen), 64'd0);
    check(done && observed() == expected(VECS[7]), "R11 paced result",
          64'(observed()), 64'(expected(VECS[7])));
    held = observed();
    @(negedge clk);
    check(done == 1'b0, "R11 done is one cycle", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    check(observed() == held, "R11 results held", 64'(observed()), 64'(held));

    // R12: reset in the middle of a displacement, then a fresh operand
    {rex_r, rex_x, rex_b} = 3'b000;
    @(negedge clk); in_valid = 1'b1; in_byte = 8'h05;
    @(negedge clk); in_byte = 8'h78;
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check(!done && !in_ready && observed() == 54'd0, "R12 reset clears",
          64'(observed()), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(VECS[5], 0, gseen);
    check(done && observed() == expected(VECS[5]), "R12 fresh decode after abort",
          64'(observed()), 64'(expected(VECS[5])));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule